// File: doc/BRIEF.md
# Microcoded Register Bus Datapath

This block is the register bank of a small microprogrammed stack-machine interpreter. It holds a set of 32-bit general registers and one 8-bit byte register that the memory side fills. A microinstruction chooses one source for the B bus and any set of destinations for the C bus. Reading a source onto the B bus and writing the C-bus value into registers both happen within one clock cycle.

The B-bus source select is one-hot. The low NREG bits select the general registers. The next bit reads the byte register as a signed value, with its sign extended. The bit above that reads the byte register as an unsigned value, with zeros above it. If no bit is set, the bus reads zero. If more than one bit is set, the microinstruction is illegal, and the bus also reads zero. The C-bus write-enable mask has one bit per general register, so one C-bus value can land in several registers on the same edge. The byte register has no C-bus path. It loads only from the memory-side byte input when that input's load strobe is high.

Top module: `regbus_dpath`

## Requirements
- R1: After synchronous reset, every general register and the byte register hold zero, so every single-source read returns 0.
- R2: When only b_sel bit i is set (0 <= i < NREG), b_bus shows the full 32-bit content of general register i in the same cycle, with no clock edge in between.
- R3: At a rising edge with c_we bit i set, general register i captures c_bus. When several bits are set, every selected register captures the same value.
- R4: A general register whose c_we bit is clear at an edge keeps its value.
- R5: A register written at an edge shows the new value only after that edge. In the cycle that presents the write, the B bus still reads the old value.
- R6: The byte register loads mem_byte at a rising edge when mem_byte_ld is high and holds its value otherwise. c_bus and c_we never change it.
- R7: When only b_sel bit NREG is set (signed read), b_bus[7:0] is the byte register and every bit of b_bus[31:8] equals its bit 7.
- R8: When only b_sel bit NREG+1 is set (unsigned read), b_bus[7:0] is the byte register and b_bus[31:8] is zero.
- R9: When b_sel is all zero, b_bus is zero.
- R10: When b_sel has two or more bits set, b_bus is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| b_sel | input | NREG+2 | One-hot B-bus source select: registers, then signed byte, then unsigned byte |
| c_bus | input | DW | Value to write into the general registers |
| c_we | input | NREG | Per-register C-bus write enable |
| mem_byte | input | BW | Byte from the memory side |
| mem_byte_ld | input | 1 | Load strobe for the byte register |
| b_bus | output | DW | B-bus value |

## Verification
A register that is corrupt, misses a write or takes a stray one shows up wrong on b_bus as soon as it is selected. Because the read path has no registers, the fault appears in the same cycle as the select. The byte register is read in both modes after each load, so a wrong upper fill or a lost load appears in the first read after the edge. The bench also places a read in the very cycle that presents a write, which exposes any hidden bypass or extra delay as a one-cycle mismatch.

// File: rtl/regbus_pkg.sv
package regbus_pkg;
  // True when more than one bit of a select word is set
  function automatic logic multi_hot(input logic [63:0] v);
    return (v & (v - 64'd1)) != 64'd0;
  endfunction
endpackage

// File: rtl/regbus_regfile.sv
module regbus_regfile #(
  parameter int DW   = 32,
  parameter int NREG = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [DW-1:0]             c_bus,
  input  logic [NREG-1:0]           c_we,
  output logic [NREG-1:0][DW-1:0]   regs_q
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)          regs_q[g] <= '0;
      else if (c_we[g]) regs_q[g] <= c_bus;
    end
  end
endmodule

// File: rtl/regbus_byte_reg.sv
module regbus_byte_reg #(
  parameter int DW = 32,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [BW-1:0] mem_byte,
  input  logic          mem_byte_ld,
  output logic [DW-1:0] word_s,
  output logic [DW-1:0] word_u
);
  localparam int FILL = DW - BW;
  logic [BW-1:0] byte_q;

  always_ff @(posedge clk) begin
    if (rst)              byte_q <= '0;
    else if (mem_byte_ld) byte_q <= mem_byte;
  end

  assign word_s = {{FILL{byte_q[BW-1]}}, byte_q};
  assign word_u = {{FILL{1'b0}}, byte_q};
endmodule

// File: rtl/regbus_bmux.sv
module regbus_bmux #(
  parameter int DW   = 32,
  parameter int NSRC = 10
) (
  input  logic [NSRC-1:0]         sel,
  input  logic [NSRC-1:0][DW-1:0] srcs,
  output logic [DW-1:0]           bus
);
  import regbus_pkg::*;
  logic illegal;

  assign illegal = multi_hot(64'(sel));

  always_comb begin
    bus = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (sel[i]) bus = bus | srcs[i];
    end
    if (illegal) bus = '0;
  end
endmodule

// File: rtl/regbus_dpath.sv
module regbus_dpath #(
  parameter int DW   = 32,
  parameter int NREG = 8,
  parameter int BW   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NREG+1:0]   b_sel,
  input  logic [DW-1:0]     c_bus,
  input  logic [NREG-1:0]   c_we,
  input  logic [BW-1:0]     mem_byte,
  input  logic              mem_byte_ld,
  output logic [DW-1:0]     b_bus
);
  localparam int NSRC = NREG + 2;

  logic [NREG-1:0][DW-1:0] regs_q;
  logic [DW-1:0]           word_s, word_u;
  logic [NSRC-1:0][DW-1:0] srcs;

  regbus_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk(clk), .rst(rst), .c_bus(c_bus), .c_we(c_we), .regs_q(regs_q)
  );

  regbus_byte_reg #(.DW(DW), .BW(BW)) u_byte (
    .clk(clk), .rst(rst), .mem_byte(mem_byte), .mem_byte_ld(mem_byte_ld),
    .word_s(word_s), .word_u(word_u)
  );

  always_comb begin
    for (int i = 0; i < NREG; i++) srcs[i] = regs_q[i];
    srcs[NREG]   = word_s;
    srcs[NREG+1] = word_u;
  end

  regbus_bmux #(.DW(DW), .NSRC(NSRC)) u_mux (
    .sel(b_sel), .srcs(srcs), .bus(b_bus)
  );
endmodule

// File: rtl/regbus_chk.sv
module regbus_chk #(
  parameter int DW   = 32,
  parameter int NREG = 8,
  parameter int BW   = 8
) (
  input logic            clk,
  input logic            rst,
  input logic [NREG+1:0] b_sel,
  input logic [DW-1:0]   c_bus,
  input logic [NREG-1:0] c_we,
  input logic [BW-1:0]   mem_byte,
  input logic            mem_byte_ld,
  input logic [DW-1:0]   b_bus
);
  localparam logic [NREG+1:0] SEL_S = (NREG+2)'(1) << NREG;
  localparam logic [NREG+1:0] SEL_U = (NREG+2)'(1) << (NREG+1);

  // R10
  multi_sel_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(b_sel) > 1) |-> (b_bus == '0));
  // R9
  no_sel_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (b_sel == '0) |-> (b_bus == '0));
  // R7
  signed_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (b_sel == SEL_S) |-> (b_bus[DW-1:BW] == {(DW-BW){b_bus[BW-1]}}));
  // R8
  unsigned_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (b_sel == SEL_U) |-> (b_bus[DW-1:BW] == '0));
  // R6
  byte_load_chk: assert property (@(posedge clk) disable iff (rst)
    mem_byte_ld |=> ((b_sel == SEL_U) -> (b_bus[BW-1:0] == $past(mem_byte))));

  for (genvar g = 0; g < NREG; g++) begin : g_wr
    // R3
    reg_write_chk: assert property (@(posedge clk) disable iff (rst)
      c_we[g] |=> ((b_sel == (NREG+2)'(1) << g) -> (b_bus == $past(c_bus))));
  end
endmodule

bind regbus_dpath regbus_chk #(.DW(DW), .NREG(NREG), .BW(BW)) u_chk (
  .clk(clk), .rst(rst), .b_sel(b_sel), .c_bus(c_bus), .c_we(c_we),
  .mem_byte(mem_byte), .mem_byte_ld(mem_byte_ld), .b_bus(b_bus)
);

// File: tb/regbus_dpath_bench.sv
`timescale 1ns/1ps
module regbus_dpath_bench;
  localparam int DW = 32, NREG = 8, BW = 8;
  localparam logic [NREG+1:0] SEL_S = 10'b01_0000_0000;
  localparam logic [NREG+1:0] SEL_U = 10'b10_0000_0000;

  logic clk = 0, rst = 1;
  logic [NREG+1:0] b_sel = '0;
  logic [DW-1:0]   c_bus = '0;
  logic [NREG-1:0] c_we = '0;
  logic [BW-1:0]   mem_byte = '0;
  logic            mem_byte_ld = 0;
  logic [DW-1:0]   b_bus;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  regbus_dpath #(.DW(DW), .NREG(NREG), .BW(BW)) u_regbus_dpath (
    .clk(clk), .rst(rst), .b_sel(b_sel), .c_bus(c_bus), .c_we(c_we),
    .mem_byte(mem_byte), .mem_byte_ld(mem_byte_ld), .b_bus(b_bus)
  );

  task automatic rd(input logic [NREG+1:0] s, input logic [DW-1:0] exp, input string req);
    b_sel = s;
    #0.5;
    total++;
    if (b_bus !== exp) begin
      bad++;
      $display("FAIL %s sel=%b got=%h exp=%h", req, s, b_bus, exp);
    end
  endtask

  task automatic wr(input logic [NREG-1:0] we, input logic [DW-1:0] d);
    @(negedge clk);
    c_we = we; c_bus = d;
    @(posedge clk); #0.5;
    c_we = '0;
  endtask

  task automatic ldb(input logic [BW-1:0] v);
    @(negedge clk);
    mem_byte = v; mem_byte_ld = 1;
    @(posedge clk); #0.5;
    mem_byte_ld = 0;
  endtask

  task automatic t_reset;
    for (int i = 0; i < NREG; i++) rd(10'(1) << i, '0, "R1");
    rd(SEL_S, '0, "R1");
    rd(SEL_U, '0, "R1");
  endtask

  task automatic t_single;
    wr(8'b0000_0100, 32'hDEAD_BEEF);
    rd(10'b00_0000_0100, 32'hDEAD_BEEF, "R2");
    rd(10'b00_0000_1000, 32'h0, "R4");
  endtask

  task automatic t_multi;
    wr(8'b1001_0010, 32'h1234_5678);
    rd(10'b00_0000_0010, 32'h1234_5678, "R3");
    rd(10'b00_0001_0000, 32'h1234_5678, "R3");
    rd(10'b00_1000_0000, 32'h1234_5678, "R3");
    rd(10'b00_0000_0100, 32'hDEAD_BEEF, "R4");
  endtask

  task automatic t_no_bypass;
    @(negedge clk);
    c_we = 8'b0010_0000; c_bus = 32'hA5A5_0001;
    rd(10'b00_0010_0000, 32'h0, "R5");
    @(posedge clk); #0.5;
    c_we = '0;
    rd(10'b00_0010_0000, 32'hA5A5_0001, "R5");
  endtask

  task automatic t_byte;
    ldb(8'h85);
    rd(SEL_S, 32'hFFFF_FF85, "R7");
    rd(SEL_U, 32'h0000_0085, "R8");
    ldb(8'h7F);
    rd(SEL_S, 32'h0000_007F, "R7");
    rd(SEL_U, 32'h0000_007F, "R8");
    @(negedge clk); mem_byte = 8'hC3;
    @(posedge clk); #0.5;
    rd(SEL_U, 32'h0000_007F, "R6");
    wr('1, 32'hFFFF_FFFF);
    rd(SEL_U, 32'h0000_007F, "R6");
    rd(10'b00_0000_0001, 32'hFFFF_FFFF, "R3");
  endtask

  task automatic t_sel_edge;
    rd('0, '0, "R9");
    rd(10'b00_0000_0011, '0, "R10");
    rd(SEL_S | SEL_U, '0, "R10");
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #0.5 rst = 0;
    @(negedge clk);
    t_reset();
    t_single();
    t_multi();
    t_no_bypass();
    t_byte();
    t_sel_edge();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule